// File: doc/BRIEF.md
# Condition-Flag ALU

This block is the arithmetic and logic stage of a small accumulator-style processor. Its data path is one byte wide and it also has a 16-bit word mode. The operand fetch logic presents two operands, a 4-bit operation code, a width select and the current carry from the condition register. In the same cycle the block returns the result and the candidate flag vector.

A per-operation mask chooses which of the five flags (carry, zero, negative, half-carry, overflow) the operation may change. Flags outside the mask pass through from the block's own flag register. That register captures the candidate vector on a clock edge when the enable is high.

All arithmetic flags come from carry and borrow terms on single bits of the two operands and the result. Overflow is the carry out of the top bit XOR the carry out of the bit below it. Half-carry is the carry out of bit 3 for bytes and out of bit 7 for words. Writing the result back is left to the surrounding data path.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 INC, 6 DEC, 7 NEG, 8 CPL, 9 SLL, 10 SRL, 11 SRA, 12 RLC, 13 RRC, 14 SWAP, 15 PASS. Flag vector bits: 0 C, 1 Z, 2 N, 3 H, 4 V. ADD returns A+B and ADC returns A+B+carry_in. For both, C is the carry out of the top bit, V is signed overflow, and H is the carry out of bit 3 (byte) or bit 7 (word).
- R2: With `wide` low only the low byte of each operand is used and result bits 15:8 are zero; with `wide` high all 16 bits take part.
- R3: N is the top bit of the result at the selected width and Z is set when that result is zero; for CMP both refer to the difference A-B.
- R4: SUB returns A-B and SBC returns A-B-carry_in. For both, C is set on a borrow out of the top bit and V on signed overflow. CMP computes the same A-B flags but returns A unchanged as its result.
- R5: INC returns A+1 and DEC returns A-1, updating V, N and Z only; V is set when INC starts at the largest positive value or DEC at the most negative value.
- R6: NEG returns 0-A, with V set only for A = 0x80 (byte) or 0x8000 (word) and C set whenever A is nonzero. CPL returns the bitwise inverse of A and always sets C.
- R7: SLL shifts A left and puts the old top bit in C. SRL shifts A right, filling the top bit with zero. SRA shifts A right and keeps the top bit. Both right shifts put the old bit 0 in C.
- R8: RLC shifts A left, puts carry_in in bit 0 and the old top bit in C. RRC shifts A right, puts carry_in in the top bit and the old bit 0 in C.
- R9: SWAP exchanges the two nibbles of a byte or the two bytes of a word, and PASS returns B; both update N and Z only.
- R10: Flags each operation may change: ADD/ADC all five; SUB/SBC/CMP/NEG C, Z, N, V; INC/DEC Z, N, V; CPL and the shifts and rotates C, Z, N; SWAP/PASS Z, N. Every other bit of `flags_next` equals the same bit of `flags_q`.
- R11: `flags_q` is zero after reset, loads `flags_next` on a rising clock edge with `en` high, and holds its value while `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Flag register update enable |
| op | input | 4 | Operation code (R1) |
| wide | input | 1 | 1 = word operation, 0 = byte operation |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| carry_in | input | 1 | Carry bit from the condition register |
| result | output | 16 | Operation result, zero-extended in byte mode |
| flags_next | output | 5 | Candidate flag vector after masking |
| flags_q | output | 5 | Registered flag vector |

## Verification
A wrong carry or borrow term, or a wrong bit choice for overflow or half-carry, shows up on `flags_next` in the same cycle as the operands. The only exception is the input combination that happens to set that one bit. The sweeps run every byte value and a spread of word values through every operation, so such a fault is visible immediately. A masking fault shows up as a flag that follows the new operands when it should hold its earlier value, so the sweeps run with known, nonzero prior flags. A fault in the flag register shows up on `flags_q` one edge after an enabled or a held cycle.

// File: rtl/afu_pkg.sv
`timescale 1ns/100ps
package afu_pkg;

    localparam int FLAG_W = 5;
    localparam int FB_C   = 0;
    localparam int FB_Z   = 1;
    localparam int FB_N   = 2;
    localparam int FB_H   = 3;
    localparam int FB_V   = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_NEG  = 4'd7,
        OP_CPL  = 4'd8,
        OP_SLL  = 4'd9,
        OP_SRL  = 4'd10,
        OP_SRA  = 4'd11,
        OP_RLC  = 4'd12,
        OP_RRC  = 4'd13,
        OP_SWAP = 4'd14,
        OP_PASS = 4'd15
    } afu_op_e;

    // Which flags an operation is allowed to write (bit order V H N Z C).
    function automatic logic [FLAG_W-1:0] op_mask(input afu_op_e op);
        logic [FLAG_W-1:0] mk;
        unique case (op)
            OP_ADD, OP_ADC:                          mk = 5'b11111;
            OP_SUB, OP_SBC, OP_CMP, OP_NEG:          mk = 5'b10111;
            OP_INC, OP_DEC:                          mk = 5'b10110;
            OP_CPL, OP_SLL, OP_SRL, OP_SRA,
            OP_RLC, OP_RRC:                          mk = 5'b00111;
            default:                                 mk = 5'b00110;
        endcase
        return mk;
    endfunction

endpackage

// File: rtl/afu_arith.sv
`timescale 1ns/100ps
// Adder/subtractor of width W. Flags are derived from single bits of the
// operands and the result: carry (or borrow) out of bit k is recovered
// from x[k], m[k] and r[k].
module afu_arith #(
    parameter int W  = 8,
    parameter int HB = 3
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] m,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c_o,
    output logic         v_o,
    output logic         h_o
);

    localparam int TOP = W - 1;
    localparam int NXT = W - 2;

    function automatic logic bit_out(input logic xb, input logic mb,
                                     input logic rb, input logic is_sub);
        if (is_sub)
            return (!xb && mb) || (!xb && rb) || (xb && mb && rb);
        else
            return (xb && mb) || (mb && !rb) || (!rb && xb);
    endfunction

    logic [W-1:0] cin_w;
    logic         top_out;
    logic         nxt_out;

    assign cin_w = {{(W-1){1'b0}}, cin};

    always_comb begin
        if (sub)
            r = x - m - cin_w;
        else
            r = x + m + cin_w;
    end

    assign top_out = bit_out(x[TOP], m[TOP], r[TOP], sub);
    assign nxt_out = bit_out(x[NXT], m[NXT], r[NXT], sub);

    assign c_o = top_out;
    assign v_o = top_out ^ nxt_out;
    assign h_o = bit_out(x[HB], m[HB], r[HB], sub);

endmodule

// File: rtl/afu_unary.sv
`timescale 1ns/100ps
// Single-operand bit operations of width W: complement, shifts, rotates
// through carry and half swap.
module afu_unary
    import afu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic         cin,
    input  afu_op_e      op,
    output logic [W-1:0] r,
    output logic         c_o
);

    localparam int HALF = W / 2;

    always_comb begin
        r   = x;
        c_o = cin;
        unique case (op)
            OP_CPL: begin
                r   = ~x;
                c_o = 1'b1;
            end
            OP_SLL: begin
                r   = {x[W-2:0], 1'b0};
                c_o = x[W-1];
            end
            OP_RLC: begin
                r   = {x[W-2:0], cin};
                c_o = x[W-1];
            end
            OP_SRL: begin
                r   = {1'b0, x[W-1:1]};
                c_o = x[0];
            end
            OP_SRA: begin
                r   = {x[W-1], x[W-1:1]};
                c_o = x[0];
            end
            OP_RRC: begin
                r   = {cin, x[W-1:1]};
                c_o = x[0];
            end
            OP_SWAP: begin
                r   = {x[HALF-1:0], x[W-1:HALF]};
            end
            default: begin
                r   = x;
            end
        endcase
    end

endmodule

// File: rtl/afu_flag_reg.sv
`timescale 1ns/100ps
module afu_flag_reg #(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [FW-1:0] d,
    output logic [FW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end

endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/100ps
module alu_flag_unit
    import afu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [3:0]          op,
    input  logic                wide,
    input  logic [2*BYTE_W-1:0] opa,
    input  logic [2*BYTE_W-1:0] opb,
    input  logic                carry_in,
    output logic [2*BYTE_W-1:0] result,
    output logic [FLAG_W-1:0]   flags_next,
    output logic [FLAG_W-1:0]   flags_q
);

    localparam int WORD_W = 2 * BYTE_W;

    afu_op_e             op_e;
    logic [WORD_W-1:0]   a_w;
    logic [WORD_W-1:0]   b_w;

    logic [WORD_W-1:0]   ar_x;
    logic [WORD_W-1:0]   ar_m;
    logic                ar_cin;
    logic                ar_sub;

    logic [WORD_W-1:0]   ar_r [2];
    logic [WORD_W-1:0]   un_r [2];
    logic [1:0]          ar_c;
    logic [1:0]          ar_v;
    logic [1:0]          ar_h;
    logic [1:0]          un_c;

    logic [WORD_W-1:0]   res;
    logic [WORD_W-1:0]   fres;
    logic                f_c;
    logic                f_v;
    logic                f_h;
    logic                f_n;
    logic                f_z;
    logic [FLAG_W-1:0]   calc;
    logic [FLAG_W-1:0]   mask;

    assign op_e = afu_op_e'(op);
    assign a_w  = wide ? opa : {{BYTE_W{1'b0}}, opa[BYTE_W-1:0]};
    assign b_w  = wide ? opb : {{BYTE_W{1'b0}}, opb[BYTE_W-1:0]};

    // Operand steering for the adder/subtractor.
    always_comb begin
        ar_x   = a_w;
        ar_m   = b_w;
        ar_cin = 1'b0;
        ar_sub = 1'b0;
        unique case (op_e)
            OP_ADC: ar_cin = carry_in;
            OP_SUB, OP_CMP: ar_sub = 1'b1;
            OP_SBC: begin
                ar_sub = 1'b1;
                ar_cin = carry_in;
            end
            OP_INC: ar_m = {{(WORD_W-1){1'b0}}, 1'b1};
            OP_DEC: begin
                ar_m   = {{(WORD_W-1){1'b0}}, 1'b1};
                ar_sub = 1'b1;
            end
            OP_NEG: begin
                ar_x   = '0;
                ar_m   = a_w;
                ar_sub = 1'b1;
            end
            default: ;
        endcase
    end

    // One arithmetic and one unary unit per operand width.
    for (genvar g = 0; g < 2; g++) begin : g_width
        localparam int GW = (g == 0) ? BYTE_W : WORD_W;
        localparam int GH = (g == 0) ? (BYTE_W / 2 - 1) : (BYTE_W - 1);

        logic [GW-1:0] r_l;
        logic [GW-1:0] u_l;
        logic          c_l;
        logic          v_l;
        logic          h_l;
        logic          uc_l;

        afu_arith #(.W(GW), .HB(GH)) u_arith (
            .x   (ar_x[GW-1:0]),
            .m   (ar_m[GW-1:0]),
            .cin (ar_cin),
            .sub (ar_sub),
            .r   (r_l),
            .c_o (c_l),
            .v_o (v_l),
            .h_o (h_l)
        );

        afu_unary #(.W(GW)) u_unary (
            .x   (a_w[GW-1:0]),
            .cin (carry_in),
            .op  (op_e),
            .r   (u_l),
            .c_o (uc_l)
        );

        assign ar_r[g] = WORD_W'(r_l);
        assign un_r[g] = WORD_W'(u_l);
        assign ar_c[g] = c_l;
        assign ar_v[g] = v_l;
        assign ar_h[g] = h_l;
        assign un_c[g] = uc_l;
    end

    // Result and raw flag selection.
    always_comb begin
        res  = a_w;
        fres = a_w;
        f_c  = 1'b0;
        f_v  = 1'b0;
        f_h  = 1'b0;
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_INC, OP_DEC, OP_NEG: begin
                res  = ar_r[wide];
                fres = ar_r[wide];
                f_c  = ar_c[wide];
                f_v  = ar_v[wide];
                f_h  = ar_h[wide];
            end
            OP_CMP: begin
                res  = a_w;
                fres = ar_r[wide];
                f_c  = ar_c[wide];
                f_v  = ar_v[wide];
                f_h  = ar_h[wide];
            end
            OP_CPL, OP_SLL, OP_SRL, OP_SRA,
            OP_RLC, OP_RRC, OP_SWAP: begin
                res  = un_r[wide];
                fres = un_r[wide];
                f_c  = un_c[wide];
            end
            default: begin
                res  = b_w;
                fres = b_w;
            end
        endcase
    end

    assign f_n  = wide ? fres[WORD_W-1] : fres[BYTE_W-1];
    assign f_z  = (fres == '0);
    assign calc = {f_v, f_h, f_n, f_z, f_c};
    assign mask = op_mask(op_e);

    assign flags_next = (calc & mask) | (flags_q & ~mask);
    assign result     = res;

    afu_flag_reg #(.FW(FLAG_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (flags_next),
        .q     (flags_q)
    );

endmodule

// File: rtl/afu_checker.sv
`timescale 1ns/100ps
module afu_checker
    import afu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic [3:0]          op,
    input logic                wide,
    input logic [2*BYTE_W-1:0] opa,
    input logic [2*BYTE_W-1:0] result,
    input logic [FLAG_W-1:0]   flags_next,
    input logic [FLAG_W-1:0]   flags_q
);

    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] a_sel;
    assign a_sel = wide ? opa : {{BYTE_W{1'b0}}, opa[BYTE_W-1:0]};

    AST_BYTE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> result[WORD_W-1:BYTE_W] == '0); // R2

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_CMP) |-> flags_next[FB_Z] == (result == '0)); // R3

    AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> result == a_sel); // R4

    AST_CPL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CPL) |-> flags_next[FB_C]); // R6

    AST_STEP_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC || op == OP_DEC) |-> flags_next[FB_C] == flags_q[FB_C]); // R10

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> flags_q == $past(flags_next)); // R11

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(flags_q)); // R11

endmodule

bind alu_flag_unit afu_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .op         (op),
    .wide       (wide),
    .opa        (opa),
    .result     (result),
    .flags_next (flags_next),
    .flags_q    (flags_q)
);

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/100ps
module sim_alu_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        wide = 1'b0;
    logic [15:0] opa = 16'd0;
    logic [15:0] opb = 16'd0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic [4:0]  flags_next;
    logic [4:0]  flags_q;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [4:0]  mq = 5'd0;

    always #2.5 clk = ~clk;

    alu_flag_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .op         (op),
        .wide       (wide),
        .opa        (opa),
        .opb        (opb),
        .carry_in   (carry_in),
        .result     (result),
        .flags_next (flags_next),
        .flags_q    (flags_q)
    );

    function automatic string op_tag(input int o);
        case (o)
            0, 1:        return "R1";
            2, 3, 4:     return "R4";
            5, 6:        return "R5";
            7, 8:        return "R6";
            9, 10, 11:   return "R7";
            12, 13:      return "R8";
            default:     return "R9";
        endcase
    endfunction

    // Reference model written from the requirements with plain arithmetic.
    function automatic void model(input int o, input bit wd, input int ai,
                                  input int bi, input bit ci,
                                  input logic [4:0] fq,
                                  output int r, output logic [4:0] f);
        int w, msk, hm, sb, a, b, t, fr, cc;
        logic c, v, h, n, z;
        logic [4:0] mk;
        w   = wd ? 16 : 8;
        msk = (1 << w) - 1;
        hm  = wd ? 255 : 15;
        sb  = 1 << (w - 1);
        a   = ai & msk;
        b   = bi & msk;
        c = 1'b0; v = 1'b0; h = 1'b0; r = a; cc = 0;
        case (o)
            0, 1: begin
                cc = (o == 1) ? int'(ci) : 0;
                t  = a + b + cc;
                r  = t & msk;
                c  = (t > msk);
                v  = (((a ^ r) & (b ^ r) & sb) != 0);
                h  = (((a & hm) + (b & hm) + cc) > hm);
            end
            2, 3, 4: begin
                cc = (o == 3) ? int'(ci) : 0;
                t  = a - b - cc;
                r  = t & msk;
                c  = (a < b + cc);
                v  = (((a ^ b) & (a ^ r) & sb) != 0);
            end
            5: begin r = (a + 1) & msk; v = (a == sb - 1); end
            6: begin r = (a - 1) & msk; v = (a == sb); end
            7: begin r = (0 - a) & msk; v = (a == sb); c = (a != 0); end
            8: begin r = (~a) & msk; c = 1'b1; end
            9: begin r = (a << 1) & msk; c = ((a & sb) != 0); end
            10: begin r = a >> 1; c = a[0]; end
            11: begin r = (a >> 1) | (a & sb); c = a[0]; end
            12: begin r = ((a << 1) | int'(ci)) & msk; c = ((a & sb) != 0); end
            13: begin r = (a >> 1) | (ci ? sb : 0); c = a[0]; end
            14: begin
                if (wd) r = ((a << 8) | (a >> 8)) & msk;
                else    r = ((a << 4) | (a >> 4)) & msk;
            end
            default: r = b;
        endcase
        fr = r;
        if (o == 4) r = a;
        n = ((fr & sb) != 0);
        z = (fr == 0);
        case (o)
            0, 1:                 mk = 5'b11111;
            2, 3, 4, 7:           mk = 5'b10111;
            5, 6:                 mk = 5'b10110;
            8, 9, 10, 11, 12, 13: mk = 5'b00111;
            default:              mk = 5'b00110;
        endcase
        f = ({v, h, n, z, c} & mk) | (fq & ~mk);
    endfunction

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Apply one vector with the flag register held; check combinational outputs.
    task automatic apply(input int o, input bit wd, input int a, input int b,
                         input bit ci);
        int r;
        logic [4:0] f;
        @(negedge clk);
        op = 4'(o); wide = wd; opa = 16'(a); opb = 16'(b); carry_in = ci;
        #1;
        model(o, wd, a, b, ci, mq, r, f);
        check({op_tag(o), wd ? "" : " R2"}, "result", int'(result), r);
        check({op_tag(o), " R3/R10"}, "flags_next", int'(flags_next), int'(f));
    endtask

    // Apply one vector with enable high; check the registered flags after the edge.
    task automatic load(input int o, input bit wd, input int a, input int b,
                        input bit ci);
        int r;
        logic [4:0] f;
        @(negedge clk);
        op = 4'(o); wide = wd; opa = 16'(a); opb = 16'(b); carry_in = ci;
        en = 1'b1;
        model(o, wd, a, b, ci, mq, r, f);
        @(posedge clk);
        #1;
        en = 1'b0;
        check("R11", "flags_q after load", int'(flags_q), int'(f));
        mq = f;
    endtask

    function automatic int wval(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h8000;
            2: return 16'h7FFF;
            3: return 16'hFFFF;
            4: return 16'h0080;
            5: return 16'h00FF;
            6: return 16'h0100;
            7: return 16'h7F80;
            default: return ((i * 16'h0A3D) ^ (i << 9)) & 16'hFFFF;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11", "flags_q in reset", int'(flags_q), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: byte 0x7F + 0x01 gives V, H, N set and C, Z clear
        load(0, 1'b0, 8'h7F, 8'h01, 1'b0);
        check("R1", "flags_q pattern", int'(flags_q), 5'b11100);

        // R11: hold with enable low while the candidate flags differ
        apply(8, 1'b0, 8'h00, 8'h00, 1'b0);
        @(posedge clk);
        #1;
        check("R11", "flags_q hold", int'(flags_q), int'(mq));

        // Byte binary operations, every A against 16 B values, both carries
        for (int o = 0; o < 5; o++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++)
                    for (int ci = 0; ci < 2; ci++)
                        apply(o, 1'b0, a, j * 17, ci[0]);

        // Byte unary operations, every A, both carries
        for (int o = 5; o < 16; o++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++)
                    apply(o, 1'b0, a, a ^ 8'h5A, ci[0]);

        // New prior flags: byte 0x00 - 0x01 sets C and N, clears V
        load(2, 1'b0, 8'h00, 8'h01, 1'b0);
        for (int o = 5; o < 16; o++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++)
                    apply(o, 1'b0, a, a ^ 8'hA5, ci[0]);

        // Word operations
        for (int o = 0; o < 5; o++)
            for (int i = 0; i < 64; i++)
                for (int j = 0; j < 16; j++)
                    for (int ci = 0; ci < 2; ci++)
                        apply(o, 1'b1, wval(i), wval(63 - j * 4), ci[0]);
        for (int o = 5; o < 16; o++)
            for (int i = 0; i < 64; i++)
                for (int ci = 0; ci < 2; ci++)
                    apply(o, 1'b1, wval(i), wval(i) ^ 16'h3C5A, ci[0]);

        // R1: word half-carry is taken out of bit 7
        load(0, 1'b1, 16'h00FF, 16'h0001, 1'b0);
        check("R1", "word half carry", int'(flags_q[3]), 1);

        // R6: word NEG of 0x8000 sets V and C
        load(7, 1'b1, 16'h8000, 16'h0000, 1'b0);
        check("R6", "neg 0x8000 flags", int'(flags_q & 5'b10001), 5'b10001);

        // R11: second hold check after a load
        apply(15, 1'b1, 16'h0000, 16'h0000, 1'b0);
        @(posedge clk);
        #1;
        check("R11", "flags_q hold 2", int'(flags_q), int'(mq));

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R11 watchdog: actual running expected finished");
            summary();
        end
    end

endmodule